// File: doc/BRIEF.md
# Clock Output Power-State Controller

This block decides, every clock cycle, the power state of a group of clock outputs and of the PLLs that feed them. Its inputs are an active-low enable/shutdown pin, a pin that serves either as a frequency-select bit or as an active-low suspend request, and a set of static configuration words. The configuration words are a shutdown option, a pin-mode bit, a PLL suspend mask, an output suspend mask, a per-output source code and a relock wait length. From these it drives a tristate control and a run enable for each output divider, a power-down line for each PLL, and a chip-wide shutdown line.

Both external pins pass through two-flop synchronizers, and every control output is registered. A level change on a pin therefore shows at the outputs on the third rising edge after it is sampled. If a PLL is suspended, every output that takes its clock from that PLL must be suspended too. The controller enforces this itself: it adds such outputs to the effective suspend set, and it raises a configuration-error flag when the output mask left them out. When a system shutdown ends, the outputs stay tristated while a programmable relock counter runs.

Top module: `pwr_state_ctl`

## Requirements
- R1: Within three rising edges of the enable pin `oe_pin` being low, every bit of `out_tri` is 1, and it stays 1 while the pin stays low.
- R2: With `cfg_sysdown_en`=1, a low enable pin gives `sys_shutdown`=1, all `pll_pd` bits 1 and all `out_en` bits 0.
- R3: With `cfg_sysdown_en`=0, a low enable pin only tristates. `sys_shutdown` stays 0, `pll_pd` and `out_en` keep the values the suspend logic alone gives, and no relock wait follows.
- R4: With `cfg_pin_mode`=1 (suspend mode), a low `susp_pin` is a suspend request. `pll_pd[j]` equals `cfg_pll_susp[j]`, and `out_tri[i]` is 1 for every output in the effective suspend set.
- R5: With `cfg_pin_mode`=0 (select mode), `susp_pin` has no effect on `pll_pd`, `out_tri` or `out_en`, and `fsel_bit` carries the synchronized pin level. In suspend mode `fsel_bit` is 0.
- R6: Output i takes its source from code `cfg_out_src[i*SRC_W +: SRC_W]`. Code 0 is the reference, and any code above N_PLL is also treated as the reference. Code k in 1..N_PLL selects PLL k-1. The effective suspend set is `cfg_out_susp` plus every output whose source PLL bit is set in `cfg_pll_susp`.
- R7: `cfg_err` is 1 exactly when some output sourced from a PLL whose bit is set in `cfg_pll_susp` has its own bit clear in `cfg_out_susp`. This holds regardless of the pin levels.
- R8: A suspend tristates an output but does not stop it. `out_en[i]` is 0 only when shutdown is active or when the output's source PLL is powered down.
- R9: When `sys_shutdown` falls with relock length L=`cfg_relock_len`, `out_tri` stays all 1 for L+1 cycles, counted from the first cycle in which `sys_shutdown` reads 0. `relock_busy` is 1 while the counter is non-zero.
- R10: While reset is held: `out_tri` is all 1, `pll_pd` is all 1, `out_en` is all 0, and `sys_shutdown`, `cfg_err`, `relock_busy` and `fsel_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_pin | input | 1 | Active-low enable/shutdown pin (asynchronous) |
| susp_pin | input | 1 | Select bit or active-low suspend pin (asynchronous) |
| cfg_sysdown_en | input | 1 | 1: a low enable pin also powers down the chip |
| cfg_pin_mode | input | 1 | 0: select mode, 1: suspend mode |
| cfg_pll_susp | input | N_PLL | PLLs switched off during suspend |
| cfg_out_susp | input | N_OUT | Outputs tristated during suspend |
| cfg_out_src | input | N_OUT*SRC_W | Source code of each output |
| cfg_relock_len | input | RELOCK_W | Relock wait length in cycles |
| out_tri | output | N_OUT | 1 forces the output pad to tristate |
| out_en | output | N_OUT | 1 lets the output divider run |
| pll_pd | output | N_PLL | 1 powers the PLL down |
| sys_shutdown | output | 1 | Chip-wide shutdown active |
| relock_busy | output | 1 | Relock wait counter running |
| cfg_err | output | 1 | Suspend masks violate the source dependencies |
| fsel_bit | output | 1 | Frequency-select bit forwarded in select mode |

## Verification
A corrupted effective suspend set shows up as a wrong `out_tri` bit or a wrong `cfg_err` level, visible three edges after the configuration or a pin settles. A stuck synchronizer stage or a dropped shutdown term leaves `pll_pd` or `out_en` wrong for as long as the pin is held. A relock counter that loads or decrements wrongly changes how many cycles `out_tri` remains high after `sys_shutdown` falls, so counting that run exposes an off-by-one in the very first wait after release.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic {
    PIN_SELECT  = 1'b0,
    PIN_SUSPEND = 1'b1
  } pin_mode_e;

  function automatic pin_mode_e to_mode(input logic b);
    return b ? PIN_SUSPEND : PIN_SELECT;
  endfunction
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pwr_dep_check.sv
module pwr_dep_check #(
  parameter int unsigned N_OUT = 6,
  parameter int unsigned N_PLL = 3,
  parameter int unsigned SRC_W = 2
) (
  input  logic [N_OUT*SRC_W-1:0] out_src,
  input  logic [N_PLL-1:0]       pll_mask,
  input  logic [N_OUT-1:0]       out_mask,
  output logic [N_OUT*N_PLL-1:0] src_onehot,
  output logic [N_OUT-1:0]       eff_mask,
  output logic                   mask_err
);
  logic [N_OUT-1:0] forced;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [SRC_W-1:0] code;
    logic [N_PLL-1:0] oh;
    assign code = out_src[i*SRC_W +: SRC_W];
    for (genvar j = 0; j < N_PLL; j++) begin : g_pll
      assign oh[j] = (code == SRC_W'(j + 1));
    end
    assign src_onehot[i*N_PLL +: N_PLL] = oh;
    assign forced[i] = |(oh & pll_mask);
  end

  assign eff_mask = out_mask | forced;
  assign mask_err = |(forced & ~out_mask);
endmodule

// File: rtl/pwr_relock_timer.sv
module pwr_relock_timer #(
  parameter int unsigned RELOCK_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shut_now,
  input  logic [RELOCK_W-1:0] load_len,
  output logic                shut_q,
  output logic                release_pulse,
  output logic                busy
);
  logic [RELOCK_W-1:0] cnt;

  assign release_pulse = shut_q & ~shut_now;
  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= 1'b0;
      cnt    <= '0;
    end else begin
      shut_q <= shut_now;
      if (shut_now)           cnt <= '0;
      else if (release_pulse) cnt <= load_len;
      else if (busy)          cnt <= cnt - 1'b1;
    end
  end

  AST_NO_COUNT_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |-> !busy); // R9
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int unsigned N_OUT    = 6,
  parameter int unsigned N_PLL    = 3,
  parameter int unsigned SRC_W    = $clog2(N_PLL + 1),
  parameter int unsigned RELOCK_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   oe_pin,
  input  logic                   susp_pin,
  input  logic                   cfg_sysdown_en,
  input  logic                   cfg_pin_mode,
  input  logic [N_PLL-1:0]       cfg_pll_susp,
  input  logic [N_OUT-1:0]       cfg_out_susp,
  input  logic [N_OUT*SRC_W-1:0] cfg_out_src,
  input  logic [RELOCK_W-1:0]    cfg_relock_len,
  output logic [N_OUT-1:0]       out_tri,
  output logic [N_OUT-1:0]       out_en,
  output logic [N_PLL-1:0]       pll_pd,
  output logic                   sys_shutdown,
  output logic                   relock_busy,
  output logic                   cfg_err,
  output logic                   fsel_bit
);
  import pwr_state_pkg::*;

  logic oe_s, susp_s;
  logic shut_now, release_pulse, susp_act;
  logic [N_OUT*N_PLL-1:0] src_onehot;
  logic [N_OUT-1:0] eff_mask, tri_d, en_d;
  logic [N_PLL-1:0] pd_d;
  logic mask_err;
  pin_mode_e mode;

  pwr_pin_sync #(.W(1), .RST_VAL(1'b0)) u_oe_sync (
    .clk(clk), .rst_n(rst_n), .d(oe_pin), .q(oe_s));
  pwr_pin_sync #(.W(1), .RST_VAL(1'b1)) u_susp_sync (
    .clk(clk), .rst_n(rst_n), .d(susp_pin), .q(susp_s));

  pwr_dep_check #(.N_OUT(N_OUT), .N_PLL(N_PLL), .SRC_W(SRC_W)) u_dep (
    .out_src(cfg_out_src), .pll_mask(cfg_pll_susp), .out_mask(cfg_out_susp),
    .src_onehot(src_onehot), .eff_mask(eff_mask), .mask_err(mask_err));

  assign mode     = to_mode(cfg_pin_mode);
  assign shut_now = ~oe_s & cfg_sysdown_en;
  assign susp_act = (mode == PIN_SUSPEND) & ~susp_s;

  pwr_relock_timer #(.RELOCK_W(RELOCK_W)) u_relock (
    .clk(clk), .rst_n(rst_n), .shut_now(shut_now), .load_len(cfg_relock_len),
    .shut_q(sys_shutdown), .release_pulse(release_pulse), .busy(relock_busy));

  for (genvar j = 0; j < N_PLL; j++) begin : g_pd
    assign pd_d[j] = shut_now | (susp_act & cfg_pll_susp[j]);
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_ctl
    assign en_d[i]  = ~shut_now & ~|(src_onehot[i*N_PLL +: N_PLL] & pd_d);
    assign tri_d[i] = ~oe_s | release_pulse | relock_busy | (susp_act & eff_mask[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_tri  <= '1;
      out_en   <= '0;
      pll_pd   <= '1;
      cfg_err  <= 1'b0;
      fsel_bit <= 1'b0;
    end else begin
      out_tri  <= tri_d;
      out_en   <= en_d;
      pll_pd   <= pd_d;
      cfg_err  <= mask_err;
      fsel_bit <= (mode == PIN_SELECT) ? susp_s : 1'b0;
    end
  end

  AST_OE_LOW_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_s |=> (out_tri == '1)); // R1
  AST_SHUTDOWN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    sys_shutdown |-> (pll_pd == '1 && out_en == '0)); // R2
  AST_RELOCK_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    relock_busy |-> (out_tri == '1)); // R9
  AST_SELECT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pin_mode |=> !fsel_bit); // R5

  for (genvar i = 0; i < N_OUT; i++) begin : g_ast
    for (genvar j = 0; j < N_PLL; j++) begin : g_src
      AST_DEP_TRI: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cfg_out_src) && pll_pd[j] &&
         cfg_out_src[i*SRC_W +: SRC_W] == SRC_W'(j + 1)) |-> out_tri[i]); // R6
      AST_DEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cfg_out_src) && pll_pd[j] &&
         cfg_out_src[i*SRC_W +: SRC_W] == SRC_W'(j + 1)) |-> !out_en[i]); // R8
    end
  end
endmodule

// File: tb/sim_pwr_state_ctl.sv
module sim_pwr_state_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NO = 6, NP = 3, SW = 2, RW = 16;

  logic clk = 0, rst_n = 0;
  logic oe_pin = 1, susp_pin = 1, cfg_sysdown_en = 0, cfg_pin_mode = 0;
  logic [NP-1:0] cfg_pll_susp = '0;
  logic [NO-1:0] cfg_out_susp = '0;
  logic [NO*SW-1:0] cfg_out_src = '0;
  logic [RW-1:0] cfg_relock_len = '0;
  logic [NO-1:0] out_tri, out_en;
  logic [NP-1:0] pll_pd;
  logic sys_shutdown, relock_busy, cfg_err, fsel_bit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl #(.N_OUT(NO), .N_PLL(NP), .SRC_W(SW), .RELOCK_W(RW)) u0 (
    .clk, .rst_n, .oe_pin, .susp_pin, .cfg_sysdown_en, .cfg_pin_mode,
    .cfg_pll_susp, .cfg_out_susp, .cfg_out_src, .cfg_relock_len,
    .out_tri, .out_en, .pll_pd, .sys_shutdown, .relock_busy, .cfg_err, .fsel_bit);

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic int src_of(input int i);
    return int'(cfg_out_src[i*SW +: SW]);
  endfunction

  function automatic logic [NO-1:0] m_eff();
    logic [NO-1:0] m = cfg_out_susp;
    for (int i = 0; i < NO; i++)
      if (src_of(i) >= 1 && src_of(i) <= NP && cfg_pll_susp[src_of(i)-1]) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic m_err();
    return |(m_eff() & ~cfg_out_susp);
  endfunction

  function automatic logic m_susp();
    return cfg_pin_mode & ~susp_pin;
  endfunction

  function automatic logic m_shut();
    return ~oe_pin & cfg_sysdown_en;
  endfunction

  function automatic logic [NP-1:0] m_pd();
    return m_shut() ? '1 : (m_susp() ? cfg_pll_susp : '0);
  endfunction

  function automatic logic [NO-1:0] m_tri();
    return ~oe_pin ? '1 : (m_susp() ? m_eff() : '0);
  endfunction

  function automatic logic [NO-1:0] m_en();
    logic [NO-1:0] e = '0;
    logic [NP-1:0] pd = m_pd();
    if (!m_shut())
      for (int i = 0; i < NO; i++)
        e[i] = !(src_of(i) >= 1 && src_of(i) <= NP && pd[src_of(i)-1]);
    return e;
  endfunction

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({"R1/R4 ", tag}, "out_tri", out_tri, m_tri());
    chk({"R8 ", tag}, "out_en", out_en, m_en());
    chk({"R2/R4 ", tag}, "pll_pd", pll_pd, m_pd());
    chk({"R3 ", tag}, "sys_shutdown", sys_shutdown, m_shut());
    chk({"R7 ", tag}, "cfg_err", cfg_err, m_err());
    chk({"R5 ", tag}, "fsel_bit", fsel_bit, cfg_pin_mode ? 0 : susp_pin);
    chk({"R9 ", tag}, "relock_busy", relock_busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "out_tri", out_tri, {NO{1'b1}});
    chk("R10", "pll_pd", pll_pd, {NP{1'b1}});
    chk("R10", "out_en", out_en, 0);
    chk("R10", "sys_shutdown", sys_shutdown, 0);
    chk("R10", "flags", {cfg_err, relock_busy, fsel_bit}, 0);
    rst_n = 1;
    settle();
    check_all("idle");

    // R3: enable low without system shutdown only tristates
    cfg_pll_susp = 3'b010; cfg_out_susp = 6'b000100; cfg_out_src = 12'b00_01_10_11_10_01;
    cfg_pin_mode = 1; susp_pin = 1; oe_pin = 0; settle();
    check_all("oe low no sysdown");
    oe_pin = 1; @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R3", "no relock after tristate-only", relock_busy, 0);
    settle();

    // R6/R7 dependency: PLL1 suspended, outputs 1 and 3 sourced from it
    susp_pin = 0; settle();
    check_all("dep force");
    chk("R6", "forced outputs tri", out_tri, 6'b001110);
    chk("R7", "err flagged", cfg_err, 1);
    chk("R8", "ref output keeps running", out_en[5], 1);

    // R5: select mode ignores pin for suspend, forwards it
    cfg_pin_mode = 0; susp_pin = 0; settle();
    check_all("select low");
    chk("R5", "pin ignored, no tri", out_tri, 0);
    susp_pin = 1; settle();
    chk("R5", "fsel follows pin", fsel_bit, 1);

    // R9 relock wait, L = 5
    cfg_sysdown_en = 1; cfg_relock_len = 5; oe_pin = 0; settle();
    check_all("shutdown");
    oe_pin = 1;
    cnt = 0;
    while (sys_shutdown && cnt < 20) begin @(negedge clk); cnt++; end
    chk("R9", "busy at release", relock_busy, 1);
    cnt = 0;
    while (out_tri == '1 && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R9", "tristate cycles after release", cnt, 6);
    settle();

    // random mix
    for (int it = 0; it < 150; it++) begin
      oe_pin = ($urandom % 4) != 0;
      susp_pin = $urandom % 2;
      cfg_sysdown_en = $urandom % 2;
      cfg_pin_mode = $urandom % 2;
      cfg_pll_susp = $urandom;
      cfg_out_susp = $urandom;
      cfg_out_src = $urandom;
      cfg_relock_len = $urandom % 8;
      settle();
      check_all("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule